// File: doc/BRIEF.md
# Descending Multi-Cache Entry Index Sequencer

This block defines one shared entry-index space that spans three cache structures: a second-level cache, a first-level data cache and a first-level instruction cache. Each structure owns a fixed, contiguous window of that space. Software that maintains the caches repeatedly hands the block an index together with a three-bit structure-select mask. For that index the block reports whether it names a real entry of a selected structure, and if so which structure, set and way. It also reports the next index to hand back on the following step.

The walk always runs downward. It starts at the largest positive signed value, which names no entry, and jumps straight to the highest entry of the highest selected structure. It then visits every entry of every selected structure once. It steps over the holes between windows and over the windows of structures the mask leaves out, and it ends with zero. The placement of the windows therefore fixes the order between cache levels: the second-level cache is handled first, then the data cache, then the instruction cache. An index that does not come from such a walk still yields only entries of selected structures, and its successor is the next valid entry below it.

The result is registered. It is captured on the clock edge at which the request strobe is high and held until the next request.

Top module: `idx_walk_seq`

## Requirements
- R1: While reset is asserted and after its release, until the first request, the outputs are: entry flag 0, structure code 3, set 0, way 0, next index 0x7FFFFFFF (the start value of a walk).
- R2: The outputs change only on a rising clock edge at which `req_i` is 1, and then show the result for the `index_i` and `mask_i` sampled at that edge. When `req_i` is 0, all outputs hold.
- R3: The entry map is as follows. Code 0, mask bit 0: second-level cache, 16 ways by 64 sets at 0x10000..0x103FF, way = low 4 bits of (index-0x10000), set = (index-0x10000)>>4. Code 1, mask bit 1: data cache, 8 ways by 64 sets at 0x2000..0x21FF, way = low 3 bits, set = offset>>3. Code 2, mask bit 2: instruction cache, 4 ways by 64 sets at 0x1000..0x10FF, way = low 2 bits, set = offset>>2.
- R4: If the index is not inside the window of a structure whose mask bit is 1, the entry flag is 0, the structure code is 3 and set and way are 0. This covers the start value, gaps, masked windows, zero and negative values.
- R5: For an index inside a selected window and above its base, the next index is the index minus one.
- R6: Otherwise the next index is the top entry of the highest selected window lying wholly below the index. This skips gaps and masked windows, and it applies to the start value.
- R7: When no selected entry lies below the index, the next index is 0. This includes a zero index, any negative index (MSB set) and an all-zero mask.
- R8: For a positive index, the next index is strictly smaller. The next index is never negative.
- R9: A walk from 0x7FFFFFFF that feeds each next index back visits every entry of the selected structures exactly once, in descending order, and stops at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Capture strobe for a new lookup |
| index_i | input | 32 | Current walk index |
| mask_i | input | 3 | Structure select: bit 0 L2, bit 1 L1D, bit 2 L1I |
| entry_valid_o | output | 1 | Index names an entry of a selected structure |
| struct_o | output | 2 | Structure code 0/1/2, 3 when no entry |
| set_o | output | 6 | Set of the named entry |
| way_o | output | 4 | Way of the named entry |
| next_index_o | output | 32 | Index for the following step, 0 when done |

## Verification
Every result is due exactly one clock edge after a request: it is computed from the inputs sampled at the edge where `req_i` is high and sits in a single register stage. The bench therefore drives inputs on the falling edge and compares all five outputs on the following falling edge. It also samples once just after driving, to confirm that nothing moves before the capturing edge, and once more after idle cycles with changed inputs and the strobe low, to confirm that the outputs hold.

// File: rtl/idx_seq_pkg.sv
package idx_seq_pkg;

    localparam int NUM_STRUCT = 3;

    typedef enum logic [1:0] {
        SID_L2   = 2'd0,
        SID_L1D  = 2'd1,
        SID_L1I  = 2'd2,
        SID_NONE = 2'd3
    } sid_e;

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/seq_range_unit.sv
// One structure window: entry decode and best successor candidate.
module seq_range_unit #(
    parameter int               XLEN    = 32,
    parameter logic [XLEN-1:0]  BASE    = '0,
    parameter int               SETS_LG = 6,
    parameter int               WAYS_LG = 2,
    parameter int               SET_W   = 6,
    parameter int               WAY_W   = 4
) (
    input  logic [XLEN-1:0]  cur_i,
    input  logic             en_i,
    output logic             hit_o,
    output logic [SET_W-1:0] set_o,
    output logic [WAY_W-1:0] way_o,
    output logic             cand_ok_o,
    output logic [XLEN-1:0]  cand_o
);
    localparam int              OW  = SETS_LG + WAYS_LG;
    localparam logic [XLEN-1:0] TOP = BASE + XLEN'((64'd1 << OW) - 64'd1);

    logic          nonneg;
    logic [OW-1:0] off;

    assign nonneg = ~cur_i[XLEN-1];
    // modular subtraction of the low bits yields the in-window offset
    assign off    = cur_i[OW-1:0] - BASE[OW-1:0];

    assign hit_o  = en_i && nonneg && (cur_i >= BASE) && (cur_i <= TOP);
    assign way_o  = WAY_W'(off[WAYS_LG-1:0]);
    assign set_o  = SET_W'(off[WAYS_LG +: SETS_LG]);

    always_comb begin
        cand_ok_o = 1'b0;
        cand_o    = '0;
        if (en_i && nonneg) begin
            if (cur_i > TOP) begin
                cand_ok_o = 1'b1;
                cand_o    = TOP;
            end else if (cur_i > BASE) begin
                cand_ok_o = 1'b1;
                cand_o    = cur_i - XLEN'(1);
            end
        end
    end
endmodule

// File: rtl/seq_pick.sv
// Merges per-window results; window 0 is highest in the space and wins.
module seq_pick #(
    parameter int N     = 3,
    parameter int XLEN  = 32,
    parameter int SET_W = 6,
    parameter int WAY_W = 4
) (
    input  logic [N-1:0]            hit_i,
    input  logic [N-1:0][SET_W-1:0] set_i,
    input  logic [N-1:0][WAY_W-1:0] way_i,
    input  logic [N-1:0]            ok_i,
    input  logic [N-1:0][XLEN-1:0]  cand_i,
    output logic                    hit_o,
    output logic [1:0]              id_o,
    output logic [SET_W-1:0]        set_o,
    output logic [WAY_W-1:0]        way_o,
    output logic [XLEN-1:0]         next_o
);
    always_comb begin
        hit_o  = 1'b0;
        id_o   = 2'd3;
        set_o  = '0;
        way_o  = '0;
        next_o = '0;
        for (int k = N - 1; k >= 0; k--) begin
            if (ok_i[k]) begin
                next_o = cand_i[k];
            end
            if (hit_i[k]) begin
                hit_o = 1'b1;
                id_o  = 2'(k);
                set_o = set_i[k];
                way_o = way_i[k];
            end
        end
    end
endmodule

// File: rtl/idx_walk_seq.sv
module idx_walk_seq
    import idx_seq_pkg::*;
#(
    parameter int              XLEN        = 32,
    parameter logic [XLEN-1:0] L2_BASE     = XLEN'(32'h0001_0000),
    parameter int              L2_SETS_LG  = 6,
    parameter int              L2_WAYS_LG  = 4,
    parameter logic [XLEN-1:0] L1D_BASE    = XLEN'(32'h0000_2000),
    parameter int              L1D_SETS_LG = 6,
    parameter int              L1D_WAYS_LG = 3,
    parameter logic [XLEN-1:0] L1I_BASE    = XLEN'(32'h0000_1000),
    parameter int              L1I_SETS_LG = 6,
    parameter int              L1I_WAYS_LG = 2,
    localparam int             SET_W = max3(L2_SETS_LG, L1D_SETS_LG, L1I_SETS_LG),
    localparam int             WAY_W = max3(L2_WAYS_LG, L1D_WAYS_LG, L1I_WAYS_LG)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_i,
    input  logic [XLEN-1:0]  index_i,
    input  logic [2:0]       mask_i,
    output logic             entry_valid_o,
    output logic [1:0]       struct_o,
    output logic [SET_W-1:0] set_o,
    output logic [WAY_W-1:0] way_o,
    output logic [XLEN-1:0]  next_index_o
);
    localparam logic [XLEN-1:0] START_IDX = {1'b0, {(XLEN-1){1'b1}}};

    localparam logic [XLEN-1:0] BASE_A [NUM_STRUCT] = '{L2_BASE, L1D_BASE, L1I_BASE};
    localparam int SLG_A [NUM_STRUCT] = '{L2_SETS_LG, L1D_SETS_LG, L1I_SETS_LG};
    localparam int WLG_A [NUM_STRUCT] = '{L2_WAYS_LG, L1D_WAYS_LG, L1I_WAYS_LG};

    typedef struct packed {
        logic             valid;
        sid_e             sid;
        logic [SET_W-1:0] set;
        logic [WAY_W-1:0] way;
        logic [XLEN-1:0]  next;
    } res_t;

    localparam res_t RES_RST = '{valid: 1'b0, sid: SID_NONE, set: '0, way: '0, next: START_IDX};

    logic [NUM_STRUCT-1:0]            hit_v;
    logic [NUM_STRUCT-1:0][SET_W-1:0] set_v;
    logic [NUM_STRUCT-1:0][WAY_W-1:0] way_v;
    logic [NUM_STRUCT-1:0]            ok_v;
    logic [NUM_STRUCT-1:0][XLEN-1:0]  cand_v;

    for (genvar g = 0; g < NUM_STRUCT; g++) begin : g_win
        seq_range_unit #(
            .XLEN    (XLEN),
            .BASE    (BASE_A[g]),
            .SETS_LG (SLG_A[g]),
            .WAYS_LG (WLG_A[g]),
            .SET_W   (SET_W),
            .WAY_W   (WAY_W)
        ) u_win (
            .cur_i     (index_i),
            .en_i      (mask_i[g]),
            .hit_o     (hit_v[g]),
            .set_o     (set_v[g]),
            .way_o     (way_v[g]),
            .cand_ok_o (ok_v[g]),
            .cand_o    (cand_v[g])
        );
    end

    logic             p_hit;
    logic [1:0]       p_id;
    logic [SET_W-1:0] p_set;
    logic [WAY_W-1:0] p_way;
    logic [XLEN-1:0]  p_next;

    seq_pick #(
        .N     (NUM_STRUCT),
        .XLEN  (XLEN),
        .SET_W (SET_W),
        .WAY_W (WAY_W)
    ) u_pick (
        .hit_i  (hit_v),
        .set_i  (set_v),
        .way_i  (way_v),
        .ok_i   (ok_v),
        .cand_i (cand_v),
        .hit_o  (p_hit),
        .id_o   (p_id),
        .set_o  (p_set),
        .way_o  (p_way),
        .next_o (p_next)
    );

    res_t res_d, res_q;

    always_comb begin
        res_d = res_q;
        if (req_i) begin
            res_d.valid = p_hit;
            res_d.sid   = sid_e'(p_id);
            res_d.set   = p_set;
            res_d.way   = p_way;
            res_d.next  = p_next;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_q <= RES_RST;
        end else begin
            res_q <= res_d;
        end
    end

    assign entry_valid_o = res_q.valid;
    assign struct_o      = res_q.sid;
    assign set_o         = res_q.set;
    assign way_o         = res_q.way;
    assign next_index_o  = res_q.next;

    // R2: no request, no change
    assert_hold_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !req_i |=> ($stable(entry_valid_o) && $stable(struct_o) && $stable(next_index_o)
                    && $stable(set_o) && $stable(way_o)));

    // R4: a reported entry always carries a real structure code
    assert_entry_has_sid_R4: assert property (@(posedge clk) disable iff (!rst_n)
        entry_valid_o |-> (struct_o != 2'd3));

    // R7: empty mask finishes at once
    assert_empty_mask_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && mask_i == 3'b000) |=> (!entry_valid_o && next_index_o == '0));

    // R8: strictly descending from any positive index
    assert_descends_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && !index_i[XLEN-1] && index_i != '0) |=> (next_index_o < $past(index_i)));

    // R8: successor is never a negative value
    assert_next_nonneg_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !next_index_o[XLEN-1]);
endmodule

// File: tb/tb_idx_walk_seq.sv
module tb_idx_walk_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_i = 1'b0;
    logic [31:0] index_i = '0;
    logic [2:0]  mask_i = '0;
    logic        entry_valid_o;
    logic [1:0]  struct_o;
    logic [5:0]  set_o;
    logic [3:0]  way_o;
    logic [31:0] next_index_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    idx_walk_seq dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .req_i         (req_i),
        .index_i       (index_i),
        .mask_i        (mask_i),
        .entry_valid_o (entry_valid_o),
        .struct_o      (struct_o),
        .set_o         (set_o),
        .way_o         (way_o),
        .next_index_o  (next_index_o)
    );

    // window table from R3
    function automatic void win(input int s, output longint base, output longint ways,
                                output longint sets);
        case (s)
            0: begin base = 64'h10000; ways = 16; sets = 64; end
            1: begin base = 64'h2000;  ways = 8;  sets = 64; end
            default: begin base = 64'h1000; ways = 4; sets = 64; end
        endcase
    endfunction

    function automatic void model(input logic [31:0] idx, input logic [2:0] m,
                                  output logic ev, output logic [1:0] sid,
                                  output logic [5:0] st, output logic [3:0] wy,
                                  output logic [31:0] nx);
        longint v, base, ways, sets, top, best, c;
        v = longint'(idx);
        ev = 1'b0; sid = 2'd3; st = '0; wy = '0; best = 0;
        for (int s = 0; s < 3; s++) begin
            win(s, base, ways, sets);
            top = base + ways * sets - 1;
            if (m[s] && !idx[31]) begin
                if (v >= base && v <= top) begin
                    ev = 1'b1; sid = 2'(s);
                    st = 6'((v - base) / ways);
                    wy = 4'((v - base) % ways);
                end
                c = -1;
                if (v > top) c = top;
                else if (v > base) c = v - 1;
                if (c > best) best = c;
            end
        end
        nx = 32'(best);
    endfunction

    task automatic compare(input string tag, input logic ev, input logic [1:0] sid,
                           input logic [5:0] st, input logic [3:0] wy, input logic [31:0] nx);
        checks++;
        if (entry_valid_o !== ev || struct_o !== sid || set_o !== st ||
            way_o !== wy || next_index_o !== nx) begin
            errors++;
            $display("FAIL %s idx=%h mask=%b actual v=%b s=%0d set=%0d way=%0d next=%h expected v=%b s=%0d set=%0d way=%0d next=%h",
                     tag, index_i, mask_i, entry_valid_o, struct_o, set_o, way_o, next_index_o,
                     ev, sid, st, wy, nx);
        end
    endtask

    // drive on falling edge, result due after the next rising edge
    task automatic apply(input string tag, input logic [31:0] idx, input logic [2:0] m);
        logic ev; logic [1:0] sid; logic [5:0] st; logic [3:0] wy; logic [31:0] nx;
        @(negedge clk);
        req_i = 1'b1; index_i = idx; mask_i = m;
        @(negedge clk);
        req_i = 1'b0;
        model(idx, m, ev, sid, st, wy, nx);
        compare(tag, ev, sid, st, wy, nx);
    endtask

    task automatic walk(input logic [2:0] m);
        logic [31:0] idx;
        int visited, expect_n, steps;
        idx = 32'h7FFF_FFFF;
        visited = 0; steps = 0;
        expect_n = (m[0] ? 1024 : 0) + (m[1] ? 512 : 0) + (m[2] ? 256 : 0);
        while (idx != 0 && steps < 3000) begin
            apply("R9 walk step", idx, m);
            if (entry_valid_o) visited++;
            if (steps == 0) begin
                checks++;
                if (entry_valid_o !== 1'b0) begin
                    errors++;
                    $display("FAIL R6 start value decoded as entry actual %b expected 0", entry_valid_o);
                end
            end
            checks++;
            if (next_index_o >= idx) begin
                errors++;
                $display("FAIL R8 not descending actual %h expected below %h", next_index_o, idx);
            end
            idx = next_index_o;
            steps++;
        end
        checks++;
        if (visited != expect_n || idx != 0) begin
            errors++;
            $display("FAIL R9 mask=%b actual visited=%0d end=%h expected visited=%0d end=0",
                     m, visited, idx, expect_n);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired actual running expected finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] hold_next; logic hold_v; logic [1:0] hold_s;
        logic [5:0] hold_set; logic [3:0] hold_way;
        repeat (3) @(negedge clk);
        // R1 reset state, during reset and after release
        compare("R1 in reset", 1'b0, 2'd3, 6'd0, 4'd0, 32'h7FFF_FFFF);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        compare("R1 after release", 1'b0, 2'd3, 6'd0, 4'd0, 32'h7FFF_FFFF);

        // R3 map corners, R5 in-window step
        apply("R3 L2 top",   32'h0001_03FF, 3'b111);
        apply("R3 L2 base",  32'h0001_0000, 3'b111);
        apply("R3 L2 mid",   32'h0001_0123, 3'b001);
        apply("R3 L1D top",  32'h0000_21FF, 3'b111);
        apply("R3 L1D mid",  32'h0000_20AB, 3'b010);
        apply("R3 L1I top",  32'h0000_10FF, 3'b111);
        apply("R5 L1I step", 32'h0000_1077, 3'b100);
        // R4 masked windows and gaps
        apply("R4 masked L2",  32'h0001_0200, 3'b110);
        apply("R4 gap",        32'h0000_5000, 3'b111);
        apply("R4 masked L1D", 32'h0000_2100, 3'b101);
        // R6 skips
        apply("R6 start all",    32'h7FFF_FFFF, 3'b111);
        apply("R6 start L1I",    32'h7FFF_FFFF, 3'b100);
        apply("R6 L2 base to L1I", 32'h0001_0000, 3'b101);
        apply("R6 gap to L1D",   32'h0000_3000, 3'b011);
        // R7 completion cases
        apply("R7 zero",     32'h0000_0000, 3'b111);
        apply("R7 negative", 32'h8000_0000, 3'b111);
        apply("R7 all ones", 32'hFFFF_FFFF, 3'b111);
        apply("R7 no mask",  32'h0001_0100, 3'b000);
        apply("R7 L1I base", 32'h0000_1000, 3'b111);

        // R2: no change before the capturing edge, hold while idle
        @(negedge clk);
        hold_v = entry_valid_o; hold_s = struct_o; hold_set = set_o;
        hold_way = way_o; hold_next = next_index_o;
        req_i = 1'b1; index_i = 32'h0000_2055; mask_i = 3'b111;
        #1;
        compare("R2 before edge", hold_v, hold_s, hold_set, hold_way, hold_next);
        @(negedge clk);
        req_i = 1'b0;
        hold_v = entry_valid_o; hold_s = struct_o; hold_set = set_o;
        hold_way = way_o; hold_next = next_index_o;
        compare("R2 captured", 1'b1, 2'd1, 6'd10, 4'd5, 32'h0000_2054);
        index_i = 32'h0001_0010; mask_i = 3'b001;
        repeat (3) @(negedge clk);
        compare("R2 hold idle", hold_v, hold_s, hold_set, hold_way, hold_next);

        // near-exhaustive sweep of low space and L2 window, all selected
        for (int i = 0; i < 32'h2210; i++) apply("R3 R5 R6 sweep low", 32'(i), 3'b111);
        for (int i = 32'hFFF0; i < 32'h10410; i++) apply("R3 R5 R6 sweep L2", 32'(i), 3'b111);

        // full walks for every mask
        for (int m = 0; m < 8; m++) walk(3'(m));

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule